// File: doc/BRIEF.md
# Base-and-bounds address translator

This block turns the logical addresses produced by a small in-order processor into physical addresses, using segment relocation instead of paging. It has two independent channels. The fetch channel takes the program counter. The data channel takes load and store addresses. Each channel owns one relocation base and one segment length. In user mode, the base is added to the logical address to form the physical address. An access whose logical address falls outside the segment raises a violation flag, and no memory request is issued for it.

The block also holds the privilege bit. Supervisor mode is entered only through an event: an environment call, a timer interrupt, a general trap, or an attempted register write from user mode. When such an event is taken, the current program counter is saved. The only way back to user mode is a return strobe. While the block is in supervisor mode, both channels pass addresses through untranslated. Software can then load the four segment registers through a small configuration port. That port ignores writes from user mode and returns zero on reads from user mode.

Top module: `bb_xlate`

## Requirements
- R1: In user mode, each channel drives a physical address equal to its segment base plus its logical address, modulo 2^AW.
- R2: In user mode, a channel flags a violation exactly when its logical address is greater than or equal to its segment length; the address length-1 is legal, and a length of zero rejects every address.
- R3: The fetch channel uses only the program segment registers (selector 0 = program base, 1 = program length). The data channel uses only the data segment registers (selector 2 = data base, 3 = data length).
- R4: A configuration write in supervisor mode updates the selected register at the next clock edge. In supervisor mode, `cfg_rdata` shows the selected register. In user mode, `cfg_rdata` reads zero.
- R5: In supervisor mode, both channels pass the logical address through unchanged and never flag a violation.
- R6: A channel's request valid output equals its input valid, except that it is held low whenever that channel flags a violation.
- R7: A configuration write in user mode leaves every register unchanged. One cycle later, `illegal_trap` is high for exactly one cycle and the block is in supervisor mode.
- R8: The mode becomes supervisor only after `ecall_req`, `timer_irq`, `trap_req` or a user-mode configuration write. In supervisor mode, `xret` returns the block to user mode. A trap event in the same cycle as `xret` takes priority and leaves the block in supervisor mode. `xret` in user mode has no effect.
- R9: On every cycle in which a trap event is taken, `epc` loads the fetch-channel logical address of that cycle.
- R10: After reset, the block is in supervisor mode, all four segment registers and `epc` are zero, and `illegal_trap` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecall_req | input | 1 | Environment-call trap request |
| timer_irq | input | 1 | Timer expiry interrupt |
| trap_req | input | 1 | Any other trap or interrupt |
| xret | input | 1 | Return-from-trap strobe |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_sel | input | 2 | Register selector (0 prog base, 1 prog length, 2 data base, 3 data length) |
| cfg_wdata | input | AW | Write data |
| cfg_rdata | output | AW | Selected register in supervisor mode, zero otherwise |
| if_valid | input | 1 | Fetch access valid |
| if_laddr | input | AW | Fetch logical address (program counter) |
| if_req_valid | output | 1 | Fetch memory request valid |
| if_paddr | output | AW | Fetch physical address |
| if_viol | output | 1 | Fetch segment violation |
| dm_valid | input | 1 | Data access valid |
| dm_laddr | input | AW | Data logical address |
| dm_req_valid | output | 1 | Data memory request valid |
| dm_paddr | output | AW | Data physical address |
| dm_viol | output | 1 | Data segment violation |
| sup_mode | output | 1 | Supervisor mode bit |
| epc | output | AW | Saved program counter of the last trap |
| illegal_trap | output | 1 | One-cycle pulse after a rejected user-mode write |

## Verification
The bench builds the block with AW = 16. At that width, the bench can choose a data base near the top of the address space so that base plus offset wraps past zero, and it can present a logical address of all ones to the fetch channel. The program and data segments use different bases and lengths. A channel that picked up the other channel's registers would therefore produce wrong addresses and wrong violation decisions at the segment edges (length-1 and length). The zero lengths left by reset are checked before any register is written.

// File: rtl/bb_pkg.sv
package bb_pkg;
    // Register selector encoding for the configuration port
    typedef enum logic [1:0] {
        SEL_PBASE  = 2'd0,
        SEL_PLEN   = 2'd1,
        SEL_DBASE  = 2'd2,
        SEL_DLEN   = 2'd3
    } seg_sel_e;

    localparam int NUM_CH   = 2;  // fetch and data channels
    localparam int CH_FETCH = 0;
    localparam int CH_DATA  = 1;
    localparam int NUM_REGS = 2 * NUM_CH;
endpackage

// File: rtl/bb_seg_regs.sv
module bb_seg_regs
    import bb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    sel,
    input  logic [AW-1:0]                 wdata,
    input  logic                          rd_en,
    output logic [AW-1:0]                 rdata,
    output logic [NUM_CH-1:0][AW-1:0]     base,
    output logic [NUM_CH-1:0][AW-1:0]     seglen
);
    logic [NUM_REGS-1:0][AW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d[sel] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Each channel owns an adjacent base/length pair
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pair
        assign base[c]   = regs_q[2*c];
        assign seglen[c] = regs_q[2*c+1];
    end

    assign rdata = rd_en ? regs_q[sel] : '0;
endmodule

// File: rtl/bb_mode_ctl.sv
module bb_mode_ctl #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ecall_req,
    input  logic          timer_irq,
    input  logic          trap_req,
    input  logic          bad_wr,
    input  logic          xret,
    input  logic [AW-1:0] pc,
    output logic          sup,
    output logic [AW-1:0] epc,
    output logic          illegal
);
    typedef struct packed {
        logic          sup;
        logic [AW-1:0] epc;
        logic          illegal;
    } mode_t;

    mode_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d         = st_q;
        take         = ecall_req | timer_irq | trap_req | bad_wr;
        st_d.illegal = bad_wr;
        if (take) begin
            st_d.sup = 1'b1;
            st_d.epc = pc;
        end else if (xret) begin
            st_d.sup = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sup     <= 1'b1;
            st_q.epc     <= '0;
            st_q.illegal <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sup     = st_q.sup;
    assign epc     = st_q.epc;
    assign illegal = st_q.illegal;
endmodule

// File: rtl/bb_seg_xlate.sv
module bb_seg_xlate #(
    parameter int AW = 32
) (
    input  logic          bypass,
    input  logic          valid,
    input  logic [AW-1:0] laddr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] seglen,
    output logic [AW-1:0] paddr,
    output logic          viol,
    output logic          req_valid
);
    logic [AW-1:0] reloc;
    logic          outside;

    always_comb begin
        reloc     = base + laddr;
        outside   = (laddr >= seglen);
        paddr     = bypass ? laddr : reloc;
        viol      = ~bypass & outside;
        req_valid = valid & ~viol;
    end
endmodule

// File: rtl/bb_xlate.sv
module bb_xlate
    import bb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ecall_req,
    input  logic          timer_irq,
    input  logic          trap_req,
    input  logic          xret,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          if_valid,
    input  logic [AW-1:0] if_laddr,
    output logic          if_req_valid,
    output logic [AW-1:0] if_paddr,
    output logic          if_viol,
    input  logic          dm_valid,
    input  logic [AW-1:0] dm_laddr,
    output logic          dm_req_valid,
    output logic [AW-1:0] dm_paddr,
    output logic          dm_viol,
    output logic          sup_mode,
    output logic [AW-1:0] epc,
    output logic          illegal_trap
);
    logic [NUM_CH-1:0][AW-1:0] seg_base, seg_len;
    logic [NUM_CH-1:0][AW-1:0] ch_laddr, ch_paddr;
    logic [NUM_CH-1:0]         ch_valid, ch_req, ch_viol;
    logic                      wr_ok, wr_bad;

    assign wr_ok  = cfg_we & sup_mode;
    assign wr_bad = cfg_we & ~sup_mode;

    bb_seg_regs #(.AW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .rd_en  (sup_mode),
        .rdata  (cfg_rdata),
        .base   (seg_base),
        .seglen (seg_len)
    );

    bb_mode_ctl #(.AW(AW)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecall_req (ecall_req),
        .timer_irq (timer_irq),
        .trap_req  (trap_req),
        .bad_wr    (wr_bad),
        .xret      (xret),
        .pc        (if_laddr),
        .sup       (sup_mode),
        .epc       (epc),
        .illegal   (illegal_trap)
    );

    assign ch_laddr[CH_FETCH] = if_laddr;
    assign ch_laddr[CH_DATA]  = dm_laddr;
    assign ch_valid[CH_FETCH] = if_valid;
    assign ch_valid[CH_DATA]  = dm_valid;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bb_seg_xlate #(.AW(AW)) u_xl (
            .bypass    (sup_mode),
            .valid     (ch_valid[c]),
            .laddr     (ch_laddr[c]),
            .base      (seg_base[c]),
            .seglen    (seg_len[c]),
            .paddr     (ch_paddr[c]),
            .viol      (ch_viol[c]),
            .req_valid (ch_req[c])
        );
    end

    assign if_paddr     = ch_paddr[CH_FETCH];
    assign if_viol      = ch_viol[CH_FETCH];
    assign if_req_valid = ch_req[CH_FETCH];
    assign dm_paddr     = ch_paddr[CH_DATA];
    assign dm_viol      = ch_viol[CH_DATA];
    assign dm_req_valid = ch_req[CH_DATA];
endmodule

// File: rtl/bb_xlate_chk.sv
module bb_xlate_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ecall_req,
    input logic          timer_irq,
    input logic          trap_req,
    input logic          xret,
    input logic          cfg_we,
    input logic [AW-1:0] cfg_rdata,
    input logic [AW-1:0] if_laddr,
    input logic [AW-1:0] if_paddr,
    input logic          if_viol,
    input logic          if_req_valid,
    input logic [AW-1:0] dm_laddr,
    input logic [AW-1:0] dm_paddr,
    input logic          dm_viol,
    input logic          dm_req_valid,
    input logic          sup_mode,
    input logic [AW-1:0] epc,
    input logic          illegal_trap
);
    p_rdata_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_mode |-> cfg_rdata == '0);

    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sup_mode |-> (if_paddr == if_laddr && dm_paddr == dm_laddr && !if_viol && !dm_viol));

    p_gate_if_r6: assert property (@(posedge clk) disable iff (!rst_n)
        if_viol |-> !if_req_valid);

    p_gate_dm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_viol |-> !dm_req_valid);

    p_user_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_mode && cfg_we) |=> (illegal_trap && sup_mode));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trap |=> !illegal_trap);

    p_stay_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_mode && !ecall_req && !timer_irq && !trap_req && !cfg_we) |=> !sup_mode);

    p_xret_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_mode && xret && !ecall_req && !timer_irq && !trap_req) |=> !sup_mode);

    p_epc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ecall_req || timer_irq || trap_req) |=> (epc == $past(if_laddr)));
endmodule

bind bb_xlate bb_xlate_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ecall_req    (ecall_req),
    .timer_irq    (timer_irq),
    .trap_req     (trap_req),
    .xret         (xret),
    .cfg_we       (cfg_we),
    .cfg_rdata    (cfg_rdata),
    .if_laddr     (if_laddr),
    .if_paddr     (if_paddr),
    .if_viol      (if_viol),
    .if_req_valid (if_req_valid),
    .dm_laddr     (dm_laddr),
    .dm_paddr     (dm_paddr),
    .dm_viol      (dm_viol),
    .dm_req_valid (dm_req_valid),
    .sup_mode     (sup_mode),
    .epc          (epc),
    .illegal_trap (illegal_trap)
);

// File: tb/bb_xlate_tb.sv
module bb_xlate_tb;
    localparam int AW = 16;

    typedef struct packed {
        logic [15:0] ia;
        logic [15:0] ip;
        logic        iv;
        logic [15:0] da;
        logic [15:0] dp;
        logic        dv;
    } vec_t;

    // program base 0x1000 length 0x0100, data base 0xFFE0 length 0x0040
    localparam vec_t VEC [6] = '{
        '{16'h0000, 16'h1000, 1'b0, 16'h0000, 16'hFFE0, 1'b0},
        '{16'h00FF, 16'h10FF, 1'b0, 16'h003F, 16'h001F, 1'b0},
        '{16'h0100, 16'h1100, 1'b1, 16'h0040, 16'h0020, 1'b1},
        '{16'h0050, 16'h1050, 1'b0, 16'h0030, 16'h0010, 1'b0},
        '{16'hFFFF, 16'h0FFF, 1'b1, 16'h0020, 16'h0000, 1'b0},
        '{16'h003F, 16'h103F, 1'b0, 16'h00FF, 16'h00DF, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ecall_req = 1'b0, timer_irq = 1'b0, trap_req = 1'b0, xret = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          if_valid = 1'b0, dm_valid = 1'b0;
    logic [AW-1:0] if_laddr = '0, dm_laddr = '0;
    logic          if_req_valid, if_viol, dm_req_valid, dm_viol;
    logic [AW-1:0] if_paddr, dm_paddr;
    logic          sup_mode, illegal_trap;
    logic [AW-1:0] epc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bb_xlate #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ecall_req(ecall_req), .timer_irq(timer_irq), .trap_req(trap_req), .xret(xret),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .if_valid(if_valid), .if_laddr(if_laddr), .if_req_valid(if_req_valid),
        .if_paddr(if_paddr), .if_viol(if_viol),
        .dm_valid(dm_valid), .dm_laddr(dm_laddr), .dm_req_valid(dm_req_valid),
        .dm_paddr(dm_paddr), .dm_viol(dm_viol),
        .sup_mode(sup_mode), .epc(epc), .illegal_trap(illegal_trap)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic do_xret();
        xret = 1'b1;
        tick();
        xret = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10: reset state
        chk("R10 sup", sup_mode, 1);
        chk("R10 epc", epc, 0);
        chk("R10 illegal", illegal_trap, 0);
        for (int s = 0; s < 4; s++) begin
            cfg_sel = 2'(s); #1;
            chk("R10 reg", cfg_rdata, 0);
        end

        // R5: supervisor bypass
        if_valid = 1'b1; dm_valid = 1'b1;
        if_laddr = 16'h1234; dm_laddr = 16'hBEEF; #1;
        chk("R5 if paddr", if_paddr, 16'h1234);
        chk("R5 dm paddr", dm_paddr, 16'hBEEF);
        chk("R5 viol", {if_viol, dm_viol}, 0);
        chk("R6 req valid", {if_req_valid, dm_req_valid}, 2'b11);

        // R4: supervisor writes and reads
        cfg_write(2'd0, 16'h1000);
        cfg_write(2'd1, 16'h0100);
        cfg_write(2'd2, 16'hFFE0);
        cfg_write(2'd3, 16'h0040);
        cfg_sel = 2'd0; #1; chk("R4 prog base", cfg_rdata, 16'h1000);
        cfg_sel = 2'd1; #1; chk("R4 prog len", cfg_rdata, 16'h0100);
        cfg_sel = 2'd2; #1; chk("R4 data base", cfg_rdata, 16'hFFE0);
        cfg_sel = 2'd3; #1; chk("R4 data len", cfg_rdata, 16'h0040);

        // R8: leave via return
        do_xret();
        chk("R8 xret to user", sup_mode, 0);
        chk("R4 user read zero", cfg_rdata, 0);

        // R1 R2 R3 R6: vector table
        foreach (VEC[i]) begin
            if_laddr = VEC[i].ia; dm_laddr = VEC[i].da; #1;
            chk("R1 R3 if paddr", if_paddr, VEC[i].ip);
            chk("R2 R3 if viol", if_viol, VEC[i].iv);
            chk("R6 if req", if_req_valid, !VEC[i].iv);
            chk("R1 R3 dm paddr", dm_paddr, VEC[i].dp);
            chk("R2 R3 dm viol", dm_viol, VEC[i].dv);
            chk("R6 dm req", dm_req_valid, !VEC[i].dv);
        end
        if_valid = 1'b0; dm_valid = 1'b0; if_laddr = 16'h0010; dm_laddr = 16'h0010; #1;
        chk("R6 idle no req", {if_req_valid, dm_req_valid}, 0);
        if_valid = 1'b1; dm_valid = 1'b1;

        // R8: xret in user, quiet cycles stay user
        do_xret();
        tick();
        chk("R8 stays user", sup_mode, 0);

        // R7 R9: user write rejected
        if_laddr = 16'h0042;
        cfg_write(2'd1, 16'hFFFF);
        chk("R7 illegal pulse", illegal_trap, 1);
        chk("R7 to supervisor", sup_mode, 1);
        chk("R9 epc illegal", epc, 16'h0042);
        tick();
        chk("R7 pulse ends", illegal_trap, 0);
        cfg_sel = 2'd1; #1;
        chk("R7 reg unchanged", cfg_rdata, 16'h0100);

        // R8 R9: timer
        do_xret();
        if_laddr = 16'h0077;
        timer_irq = 1'b1; tick(); timer_irq = 1'b0;
        chk("R8 timer", sup_mode, 1);
        chk("R9 epc timer", epc, 16'h0077);

        // R8: ecall with xret, trap wins
        do_xret();
        if_laddr = 16'h0021;
        ecall_req = 1'b1; xret = 1'b1; tick(); ecall_req = 1'b0; xret = 1'b0;
        chk("R8 trap beats xret", sup_mode, 1);
        chk("R9 epc ecall", epc, 16'h0021);

        // R8: general trap
        do_xret();
        if_laddr = 16'h0099;
        trap_req = 1'b1; tick(); trap_req = 1'b0;
        chk("R8 trap", sup_mode, 1);
        chk("R9 epc trap", epc, 16'h0099);

        // R2: zero length rejects all after reset
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        do_xret();
        if_laddr = 16'h0000; dm_laddr = 16'h0000; #1;
        chk("R2 zero len if", if_viol, 1);
        chk("R2 zero len dm", dm_viol, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule